// File: doc/BRIEF.md
# DRAM Column Burst Access Sequencer

This block covers the column side of a double-data-rate memory device. On every rising clock edge it looks at the command pins. A column command starts a burst of four or eight beats. Every beat's column stays inside an aligned segment whose size equals the burst length. Beats are addressed in sequential or interleaved order, depending on a type setting taken with the command.

The block also watches the spacing between column commands. It raises a one-cycle violation flag when a command comes too soon. A four-beat burst is never cut short: an early command during such a burst is dropped. An eight-beat burst gives way to the newer command.

The burst produces two beats per clock. Each beat pair is delayed by the read latency, which is the sum of the CAS latency and the additive latency. The delayed pairs appear on the outputs as a column pair with a valid strobe and a write flag.

Top module: `col_burst_seq`

## Requirements
- R1: A column command is taken only at a rising edge where cs_n=0, ras_n=1 and cas_n=0. Any other pin combination starts no burst and produces no beats.
- R2: we_n=1 at the command makes a read burst and we_n=0 makes a write burst. Every beat of the burst shows beat_wr=1 for a write and beat_wr=0 for a read.
- R3: The 11-bit burst start column is {col_addr[11], col_addr[9:0]}. col_addr[10] has no effect on any beat column.
- R4: With burst_len8=0 the burst has four beats over two consecutive clocks. Every beat keeps start-column bits [10:2] unchanged.
- R5: With burst_len8=1 the burst has eight beats over four consecutive clocks. Every beat keeps start-column bits [10:3] unchanged.
- R6: Beats are numbered b=0,1,2,… In each clock, beat_col_a carries beat 2k and beat_col_b carries beat 2k+1. With burst_il=0 the low segment bits of beat b are (start+b) mod segment size. With burst_il=1 they are start XOR b.
- R7: The first beat pair is valid in the cycle that follows the edge RL = cas_lat+add_lat edges after the command edge. The remaining pairs follow on consecutive cycles.
- R8: ccd_viol is high for exactly the one cycle after an edge that carries a column command arriving fewer than 2 edges (if the last accepted burst was four beats) or fewer than 4 edges (if it was eight beats) after the last accepted column command.
- R9: An early column command during a four-beat burst is dropped. The running burst completes and no new burst starts.
- R10: An early column command during an eight-beat burst is accepted. The old burst stops producing pairs, and the new burst's first pair takes the next slot.
- R11: Column commands spaced exactly 2 edges apart (four-beat) or 4 edges apart (eight-beat) give output pairs with no idle cycle between bursts.
- R12: After reset, beat_valid and ccd_viol are low and no burst is running. The first column command never raises ccd_viol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_addr | input | 12 | Column address pins; bit 10 is unused |
| burst_len8 | input | 1 | 1 = eight-beat burst, 0 = four-beat burst |
| burst_il | input | 1 | 1 = interleaved order, 0 = sequential order |
| cas_lat | input | 3 | CAS latency in clocks |
| add_lat | input | 3 | Additive latency in clocks |
| beat_col_a | output | 11 | Column of the first beat of the current clock |
| beat_col_b | output | 11 | Column of the second beat of the current clock |
| beat_wr | output | 1 | 1 when the beats belong to a write burst |
| beat_valid | output | 1 | Beat pair on the outputs is valid |
| ccd_viol | output | 1 | Column command spacing was violated |

## Verification
The spacing judgement and burst scheduling can fall on the same edge. An early command must both raise ccd_viol and either be dropped (four-beat) or replace the running burst (eight-beat). Directed cases place a second command one and two edges after a first, for each burst length. A random phase issues column commands on about 40 % of edges, which produces many collisions. A bench-side model tracks the last accepted command, predicts the flag and the full per-cycle beat schedule, and compares both every cycle.

// File: rtl/cbs_pkg.sv
// Shared widths and the beat-pair record passed between sequencer stages.
package cbs_pkg;
    localparam int COL_W  = 11;   // column width after dropping pin 10
    localparam int ADDR_W = 12;   // column address pin width

    typedef struct packed {
        logic             valid;
        logic             wr;
        logic [COL_W-1:0] col_a;
        logic [COL_W-1:0] col_b;
    } beat_pair_t;
endpackage

// File: rtl/cbs_cmd_decode.sv
// Decodes the sampled command pins into a column-command strobe, a write
// flag and the 11-bit start column. Assumes pins are stable at the edge.
module cbs_cmd_decode
    import cbs_pkg::*;
(
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] col_addr,
    output logic              col_cmd,
    output logic              is_wr,
    output logic [COL_W-1:0]  start_col
);
    // Pin decode; address bit 10 is not part of the column.
    always_comb begin
        col_cmd   = !cs_n && ras_n && !cas_n;
        is_wr     = !we_n;
        start_col = {col_addr[ADDR_W-1], col_addr[COL_W-2:0]};
    end
endmodule

// File: rtl/cbs_ccd_check.sv
// Tracks edges since the last accepted column command and judges each new
// one against the minimum spacing for the burst length of the last accepted
// burst. Early commands are dropped when that burst is short and accepted
// (interrupting) when it is long. Assumes the spacing limits fit in CNT_W.
module cbs_ccd_check #(
    parameter int CNT_W   = 3,
    parameter int CCD_BL4 = 2,
    parameter int CCD_BL8 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_cmd,
    input  logic bl8_in,
    output logic accept,
    output logic viol
);
    localparam logic [CNT_W-1:0] SAT  = '1;
    localparam logic [CNT_W-1:0] NEED4 = CNT_W'(CCD_BL4);
    localparam logic [CNT_W-1:0] NEED8 = CNT_W'(CCD_BL8);

    logic [CNT_W-1:0] since_cmd;
    logic             last_bl8;
    logic             early;

    // Judge the command present at this edge.
    always_comb begin
        early  = col_cmd && (since_cmd < (last_bl8 ? NEED8 : NEED4));
        accept = col_cmd && !(early && !last_bl8);
    end

    // Spacing counter, saturating; starts saturated so reset satisfies it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmd <= SAT;
            last_bl8  <= 1'b0;
        end else if (accept) begin
            since_cmd <= CNT_W'(1);
            last_bl8  <= bl8_in;
        end else if (since_cmd != SAT) begin
            since_cmd <= since_cmd + CNT_W'(1);
        end
    end

    // Violation flag registered for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) viol <= 1'b0;
        else        viol <= early;
    end

    // R8: a flagged edge always carried a column command.
    a_r8_flag_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(col_cmd));
endmodule

// File: rtl/cbs_burst_gen.sv
// Holds the running burst and emits one beat pair per clock: beats 2k and
// 2k+1 of clock k, wrapped inside the aligned 4- or 8-column segment in
// sequential or interleaved order. A start replaces any running burst.
module cbs_burst_gen
    import cbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic             start_bl8,
    input  logic             start_il,
    output beat_pair_t       pair
);
    logic             active;
    logic [COL_W-1:0] base;
    logic [1:0]       idx;
    logic             bl8_r;
    logic             il_r;
    logic             wr_r;
    logic [1:0]       last_idx;
    logic [COL_W-1:0] cols [2];

    assign last_idx = bl8_r ? 2'd3 : 2'd1;

    // Burst state: load on start, advance per clock, stop after last pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= '0;
            idx    <= '0;
            bl8_r  <= 1'b0;
            il_r   <= 1'b0;
            wr_r   <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            base   <= start_col;
            idx    <= '0;
            bl8_r  <= start_bl8;
            il_r   <= start_il;
            wr_r   <= start_wr;
        end else if (active) begin
            if (idx == last_idx) active <= 1'b0;
            else                 idx    <= idx + 2'd1;
        end
    end

    // One column generator per half-clock beat.
    for (genvar h = 0; h < 2; h++) begin : g_beat
        logic [2:0] beat_no;
        logic [2:0] low;
        // Wrap the low segment bits by sum or by XOR.
        always_comb begin
            beat_no = {idx, 1'(h)};
            low     = il_r ? (base[2:0] ^ beat_no) : (base[2:0] + beat_no);
            cols[h] = bl8_r ? {base[COL_W-1:3], low}
                            : {base[COL_W-1:2], low[1:0]};
        end
    end

    // Present the current pair.
    always_comb begin
        pair.valid = active;
        pair.wr    = wr_r;
        pair.col_a = cols[0];
        pair.col_b = cols[1];
    end

    // R4: a four-beat burst is never cut after its first pair.
    a_r4_short_runs_two: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bl8_r && idx == 2'd0) |=> (active && idx == 2'd1));
    // R11: without a new command, the burst ends after its last pair.
    a_r11_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (active && idx == last_idx && !start) |=> !active);
endmodule

// File: rtl/cbs_lat_pipe.sv
// Delays beat pairs by the read latency with a shift register and a
// selectable tap. Latency 0 is treated as 1; values beyond DEPTH clamp.
// Assumes the latency setting is changed only while no burst is in flight.
module cbs_lat_pipe
    import cbs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RL_W  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  beat_pair_t      pair_in,
    input  logic [RL_W-1:0] rl,
    output beat_pair_t      pair_out
);
    localparam int TAP_W = $clog2(DEPTH);

    beat_pair_t      stage [DEPTH];
    logic [TAP_W-1:0] tap;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        // Shift one stage per clock.
        always_ff @(posedge clk) begin
            if (!rst_n)      stage[i] <= '0;
            else if (i == 0) stage[i] <= pair_in;
            else             stage[i] <= stage[(i == 0) ? 0 : i - 1];
        end
    end

    // Pick the stage that matches the latency.
    always_comb begin
        if (rl == '0)                   tap = '0;
        else if (rl > RL_W'(DEPTH))     tap = TAP_W'(DEPTH - 1);
        else                            tap = TAP_W'(rl - RL_W'(1));
        pair_out = stage[tap];
    end
endmodule

// File: rtl/col_burst_seq.sv
// Column burst access sequencer: decode, spacing judgement, burst address
// generation and read-latency scheduling, two beats per clock.
// Assumes burst length and type are sampled with each command and that the
// latency inputs stay static while bursts are in flight.
module col_burst_seq
    import cbs_pkg::*;
#(
    parameter int MAX_RL  = 16,
    parameter int LAT_W   = 3,
    parameter int CNT_W   = 3,
    parameter int CCD_BL4 = 2,
    parameter int CCD_BL8 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [11:0]       col_addr,
    input  logic              burst_len8,
    input  logic              burst_il,
    input  logic [LAT_W-1:0]  cas_lat,
    input  logic [LAT_W-1:0]  add_lat,
    output logic [10:0]       beat_col_a,
    output logic [10:0]       beat_col_b,
    output logic              beat_wr,
    output logic              beat_valid,
    output logic              ccd_viol
);
    localparam int RL_W = $clog2(MAX_RL + 1);

    logic             col_cmd;
    logic             is_wr;
    logic [COL_W-1:0] start_col;
    logic             accept;
    logic [RL_W-1:0]  rl;
    beat_pair_t       gen_pair;
    beat_pair_t       out_pair;

    cbs_cmd_decode u_dec (
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .col_addr  (col_addr),
        .col_cmd   (col_cmd),
        .is_wr     (is_wr),
        .start_col (start_col)
    );

    cbs_ccd_check #(
        .CNT_W   (CNT_W),
        .CCD_BL4 (CCD_BL4),
        .CCD_BL8 (CCD_BL8)
    ) u_ccd (
        .clk     (clk),
        .rst_n   (rst_n),
        .col_cmd (col_cmd),
        .bl8_in  (burst_len8),
        .accept  (accept),
        .viol    (ccd_viol)
    );

    cbs_burst_gen u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_col (start_col),
        .start_wr  (is_wr),
        .start_bl8 (burst_len8),
        .start_il  (burst_il),
        .pair      (gen_pair)
    );

    // Read latency is CAS latency plus additive latency.
    assign rl = RL_W'(cas_lat) + RL_W'(add_lat);

    cbs_lat_pipe #(
        .DEPTH (MAX_RL),
        .RL_W  (RL_W)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_in  (gen_pair),
        .rl       (rl),
        .pair_out (out_pair)
    );

    // Drive the beat outputs from the delayed pair.
    always_comb begin
        beat_valid = out_pair.valid;
        beat_wr    = out_pair.wr;
        beat_col_a = out_pair.col_a;
        beat_col_b = out_pair.col_b;
    end

    // R5: both beats of a clock share one aligned eight-column block.
    a_r5_pair_same_block: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_col_a[10:3] == beat_col_b[10:3]));
    // R8: the flag follows an edge where the column pins were asserted.
    a_r8_flag_after_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ccd_viol |-> $past(!cs_n && ras_n && !cas_n));
endmodule

// File: tb/sim_col_burst_seq.sv
module sim_col_burst_seq;
    localparam int NCYC = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] col_addr = '0;
    logic        burst_len8 = 1'b0, burst_il = 1'b0;
    logic [2:0]  cas_lat = 3'd3, add_lat = 3'd0;
    logic [10:0] beat_col_a, beat_col_b;
    logic        beat_wr, beat_valid, ccd_viol;

    col_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .col_addr(col_addr), .burst_len8(burst_len8),
        .burst_il(burst_il), .cas_lat(cas_lat), .add_lat(add_lat),
        .beat_col_a(beat_col_a), .beat_col_b(beat_col_b), .beat_wr(beat_wr),
        .beat_valid(beat_valid), .ccd_viol(ccd_viol)
    );

    always #2 clk = ~clk;   // 250 MHz

    int    cyc = 0;
    int    checks = 0, errors = 0;
    bit    checking = 0, done = 0;
    bit    ev [NCYC];
    bit    ewr [NCYC];
    bit    eviol [NCYC];
    int    ea [NCYC];
    int    eb [NCYC];
    string etag [NCYC];
    string vtag [NCYC];
    string idle_tag = "R7";
    int    last_acc = -100;
    bit    last_bl8 = 0;

    always @(posedge clk) cyc = cyc + 1;

    function automatic int beat_col(int c, bit bl8, bit il, int b);
        int mask = bl8 ? 7 : 3;
        int lo = il ? ((c & mask) ^ b) : (((c & mask) + b) & mask);
        return (c & ~mask & 32'h7FF) | lo;
    endfunction

    // Reference model of acceptance, spacing and beat schedule.
    task automatic model_cmd(int n, bit wr, logic [11:0] a, bit bl8, bit il,
                             string tag);
        int  rl = int'(cas_lat) + int'(add_lat);
        int  need = last_bl8 ? 4 : 2;
        bit  early = (n - last_acc) < need;
        int  base = {a[11], a[9:0]};
        int  st;
        if (early) begin eviol[n] = 1; vtag[n] = tag; end
        if (early && !last_bl8) return;          // R9 drop
        last_acc = n; last_bl8 = bl8;
        st = n + rl;
        for (int i = 0; i < 4; i++) ev[st + i] = 0; // R10 cut
        for (int k = 0; k < (bl8 ? 4 : 2); k++) begin
            ev[st + k] = 1; ewr[st + k] = wr; etag[st + k] = tag;
            ea[st + k] = beat_col(base, bl8, il, 2 * k);
            eb[st + k] = beat_col(base, bl8, il, 2 * k + 1);
        end
    endtask

    task automatic step(bit c, bit r, bit s, bit w, logic [11:0] a, bit b8,
                        bit il, string tag);
        cs_n = c; ras_n = r; cas_n = s; we_n = w; col_addr = a;
        burst_len8 = b8; burst_il = il;
        if (!c && r && !s) model_cmd(cyc + 1, !w, a, b8, il, tag);
        @(negedge clk);
    endtask

    task automatic col(bit wr, logic [11:0] a, bit b8, bit il, string tag);
        step(0, 1, 0, !wr, a, b8, il, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 1, 1, 1, 12'h0, 0, 0, "R1");
    endtask

    task automatic chk(bit ok, string tag, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: got %0h expected %0h",
                     tag, what, cyc, got, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) if (checking && cyc < NCYC) begin
        chk(ccd_viol == eviol[cyc], eviol[cyc] ? vtag[cyc] : "R8",
            "ccd_viol", int'(ccd_viol), int'(eviol[cyc]));
        chk(beat_valid == ev[cyc], ev[cyc] ? etag[cyc] : idle_tag,
            "beat_valid", int'(beat_valid), int'(ev[cyc]));
        if (ev[cyc] && beat_valid) begin
            chk(beat_wr == ewr[cyc], "R2", "beat_wr", int'(beat_wr), int'(ewr[cyc]));
            chk(int'(beat_col_a) == ea[cyc], etag[cyc], "beat_col_a",
                int'(beat_col_a), ea[cyc]);
            chk(int'(beat_col_b) == eb[cyc], etag[cyc], "beat_col_b",
                int'(beat_col_b), eb[cyc]);
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired at cycle %0d: got hang expected finish", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(!beat_valid && !ccd_viol, "R12", "reset outputs",
            int'({beat_valid, ccd_viol}), 0);
        rst_n = 1'b1;
        checking = 1;
        // R12: first command after reset never violates
        col(0, 12'h005, 0, 0, "R12");
        idle(10);
        col(0, 12'h0A6, 0, 0, "R4");   idle(8);   // R4
        col(0, 12'h13E, 1, 0, "R5");   idle(8);   // R5
        col(0, 12'h0F5, 1, 1, "R6");   idle(8);   // R6 interleaved
        col(0, 12'h00B, 0, 1, "R6");   idle(8);
        col(0, 12'h5A7, 1, 0, "R3");   idle(8);   // R3 bit 10 set
        col(1, 12'h033, 0, 0, "R2");   idle(8);   // R2 write
        // R11: seamless at exact spacing
        col(0, 12'h010, 0, 0, "R11"); idle(1);
        col(0, 12'h022, 0, 1, "R11"); idle(1);
        col(1, 12'h031, 0, 0, "R11"); idle(8);
        col(0, 12'h104, 1, 0, "R11"); idle(3);
        col(0, 12'h20D, 1, 1, "R11"); idle(10);
        // R9: early command during four-beat burst is dropped
        col(0, 12'h046, 0, 0, "R9");
        col(1, 12'h777, 1, 1, "R9");   idle(10);
        // R10: early command interrupts eight-beat burst
        col(0, 12'h0C1, 1, 0, "R10"); idle(1);
        col(1, 12'h3F2, 0, 1, "R10"); idle(10);
        col(0, 12'h0C1, 1, 1, "R10");
        col(0, 12'h2E4, 1, 0, "R10"); idle(10);
        // R1: non-column pin patterns
        idle_tag = "R1";
        step(1, 1, 0, 1, 12'h012, 0, 0, "R1");
        step(0, 0, 0, 1, 12'h012, 0, 0, "R1");
        step(0, 0, 1, 0, 12'h012, 0, 0, "R1");
        step(1, 0, 0, 0, 12'h012, 1, 0, "R1");
        idle(12);
        idle_tag = "R7";
        // R7: other latencies
        cas_lat = 3'd4; add_lat = 3'd2; idle(20);
        col(0, 12'h155, 1, 0, "R7"); idle(3);
        col(1, 12'h266, 0, 1, "R7"); idle(20);
        cas_lat = 3'd5; add_lat = 3'd5; idle(20);
        col(0, 12'h377, 0, 0, "R7"); idle(1);
        col(0, 12'h388, 1, 1, "R7"); idle(24);
        cas_lat = 3'd4; add_lat = 3'd3; idle(20);
        // Random mix: collisions of spacing judgement and scheduling
        for (int i = 0; i < 2000; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 40)
                col(bit'($urandom_range(0, 1)), 12'($urandom_range(0, 4095)),
                    bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "R6");
            else if (r < 50)
                step(1, bit'($urandom_range(0, 1)), 0, 1, 12'h0, 0, 0, "R1");
            else if (r < 60)
                step(0, 0, bit'($urandom_range(0, 1)), 1, 12'h0, 0, 0, "R1");
            else
                idle(1);
        end
        idle(24);
        checking = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule